// File: doc/BRIEF.md
# Transmit Attempt Status Tracker

This block follows a single transmit attempt of an Ethernet MAC and assembles the status word reported for that packet. A start-of-packet strobe opens a new attempt and clears all of its state. While the attempt is open, the block counts collision pulses from the transmitter. It also measures, in bit-time ticks, how long the attempt has waited on carrier, and it records whether any waiting happened at all.

The attempt ends in one of two ways. The transmitter may signal completion. The block may also stop the attempt itself when the sixteenth collision arrives, or, with the deferral check enabled, when the wait on carrier goes beyond the deferral limit. On either end the packed status word is presented for one cycle together with a valid strobe. An abort raises a one-cycle request to the transmitter. The block then ignores all traffic until the next start-of-packet strobe.

Top module: `tx_attempt_status`

## Requirements
- R1: The status word has the following layout. Bit 0 is "had to defer". Bit 2 is "excessive deferral". Bits 6:3 hold the collision count. Bit 8 is "excessive collisions". Bits 1 and 7 and every bit from 9 upward read as zero.
- R2: Each collision pulse accepted during an open attempt adds one to the collision count, and the count is reported in bits 6:3 when the attempt completes.
- R3: The sixteenth collision of an attempt ends the attempt. In the next cycle, abort_o is high for exactly one cycle and stat_vld_o is high, with bit 8 set and bits 6:3 reading zero.
- R4: The deferral timer advances by one on each bit-time tick that arrives while defer_i is high. It ignores ticks while defer_i is low. It accumulates across separate waits within one attempt, and it saturates once it is past the limit.
- R5: With defer_chk_en_i high, a tick that arrives while deferring after more than 24288 ticks have been counted ends the attempt. In the next cycle, abort_o pulses and the status carries bit 2 and bit 0.
- R6: With defer_chk_en_i low, no length of deferral aborts the attempt or sets bit 2. If the enable is raised later, the next deferring tick ends the attempt.
- R7: Bit 0 is set if defer_i was high in any cycle while the attempt was open.
- R8: A completion strobe during an open attempt yields stat_vld_o high for one cycle in the next cycle. The status includes events that arrived in the same cycle as the strobe.
- R9: After the status of an attempt is reported, further collisions, deferrals and completion strobes produce no valid strobe, no abort and no status change until the next start-of-packet strobe.
- R10: The start-of-packet strobe clears the collision count, the deferral timer and all flags. Events in the same cycle as the strobe are ignored.
- R11: After reset, stat_o, stat_vld_o and abort_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start of a new transmit attempt |
| coll_i | input | 1 | One collision occurred this cycle |
| defer_i | input | 1 | Transmission is waiting on carrier |
| bit_tick_i | input | 1 | One bit time has elapsed |
| defer_chk_en_i | input | 1 | Enables the excessive-deferral abort |
| done_i | input | 1 | Transmission completed |
| stat_o | output | 16 | Packed status word of the last reported attempt |
| stat_vld_o | output | 1 | One-cycle strobe: stat_o is new |
| abort_o | output | 1 | One-cycle request to abandon the packet |

## Verification
Every output of this block comes from a register. A completion strobe, a sixteenth collision, or the deferring tick past the limit, if sampled at clock edge k, shows up on stat_vld_o, abort_o and stat_o right after edge k. The result is therefore visible one cycle after the stimulus was driven. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so it looks exactly at that cycle. It checks the pulse at that sample and checks that it is gone one sample later. The deferral tests count ticks precisely: the bench requires no abort after 24288 deferring ticks and requires an abort one cycle after the 24289th.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int STAT_W      = 16;
  localparam int CCNT_FLD_W  = 4;
  localparam int BIT_DEFERD  = 0;
  localparam int BIT_EXC_DEF = 2;
  localparam int CCNT_LSB    = 3;
  localparam int BIT_EXC_COL = 8;

  // Packs the per-attempt results into the status word; the collision
  // field is forced to zero when the attempt ended on collisions.
  function automatic logic [STAT_W-1:0] txs_pack(
    input logic                  exc_coll,
    input logic [CCNT_FLD_W-1:0] ccnt,
    input logic                  exc_def,
    input logic                  deferred
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[BIT_EXC_COL] = exc_coll;
    w[CCNT_LSB +: CCNT_FLD_W] = exc_coll ? '0 : ccnt;
    w[BIT_EXC_DEF] = exc_def;
    w[BIT_DEFERD]  = deferred;
    return w;
  endfunction

endpackage

// File: rtl/txs_coll_ctr.sv
module txs_coll_ctr #(
  parameter int LIMIT = 16,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         hit_i,
  output logic [W-1:0] cnt_nxt_o,
  output logic         exc_nxt_o,
  output logic         limit_o
);

  logic [W-1:0] cnt_q;
  logic         exc_q;

  assign limit_o = hit_i && !clr_i && (cnt_q == W'(LIMIT - 1));

  always_comb begin
    if (clr_i) begin
      cnt_nxt_o = '0;
      exc_nxt_o = 1'b0;
    end else begin
      cnt_nxt_o = (hit_i && !limit_o) ? cnt_q + W'(1) : cnt_q;
      exc_nxt_o = exc_q | limit_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      exc_q <= exc_nxt_o;
    end
  end

endmodule

// File: rtl/txs_defer_tmr.sv
module txs_defer_tmr #(
  parameter int LIMIT = 24288,
  parameter int W     = $clog2(LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic defer_i,
  input  logic tick_i,
  input  logic chk_en_i,
  output logic deferred_nxt_o,
  output logic exc_nxt_o,
  output logic over_o
);

  logic [W-1:0] tmr_q;
  logic [W-1:0] tmr_nxt;
  logic         deferred_q;
  logic         exc_q;
  logic         run;

  assign run    = defer_i && tick_i && !clr_i;
  assign over_o = run && chk_en_i && (tmr_q >= W'(LIMIT));

  always_comb begin
    if (clr_i) begin
      tmr_nxt        = '0;
      deferred_nxt_o = 1'b0;
      exc_nxt_o      = 1'b0;
    end else begin
      tmr_nxt        = (run && (tmr_q <= W'(LIMIT))) ? tmr_q + W'(1) : tmr_q;
      deferred_nxt_o = deferred_q | defer_i;
      exc_nxt_o      = exc_q | over_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q      <= '0;
      deferred_q <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      tmr_q      <= tmr_nxt;
      deferred_q <= deferred_nxt_o;
      exc_q      <= exc_nxt_o;
    end
  end

endmodule

// File: rtl/tx_attempt_status.sv
module tx_attempt_status #(
  parameter int COLL_LIMIT  = 16,
  parameter int DEFER_LIMIT = 24288
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sop_i,
  input  logic                      coll_i,
  input  logic                      defer_i,
  input  logic                      bit_tick_i,
  input  logic                      defer_chk_en_i,
  input  logic                      done_i,
  output logic [txs_pkg::STAT_W-1:0] stat_o,
  output logic                      stat_vld_o,
  output logic                      abort_o
);
  import txs_pkg::*;

  localparam int CCNT_W = $clog2(COLL_LIMIT);
  localparam int TMR_W  = $clog2(DEFER_LIMIT + 2);

  logic              open_q;
  logic              accept;
  logic              coll_acc;
  logic              defer_acc;
  logic [CCNT_W-1:0] ccnt_nxt;
  logic              exc_coll_nxt;
  logic              exc_def_nxt;
  logic              deferred_nxt;
  logic              coll_limit_hit;
  logic              defer_limit_hit;
  logic              abort_evt;
  logic              end_evt;

  assign accept    = open_q && !sop_i;
  assign coll_acc  = coll_i && accept;
  assign defer_acc = defer_i && accept;

  txs_coll_ctr #(.LIMIT(COLL_LIMIT), .W(CCNT_W)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (sop_i),
    .hit_i     (coll_acc),
    .cnt_nxt_o (ccnt_nxt),
    .exc_nxt_o (exc_coll_nxt),
    .limit_o   (coll_limit_hit)
  );

  txs_defer_tmr #(.LIMIT(DEFER_LIMIT), .W(TMR_W)) u_defer (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (sop_i),
    .defer_i        (defer_acc),
    .tick_i         (bit_tick_i),
    .chk_en_i       (defer_chk_en_i),
    .deferred_nxt_o (deferred_nxt),
    .exc_nxt_o      (exc_def_nxt),
    .over_o         (defer_limit_hit)
  );

  assign abort_evt = coll_limit_hit || defer_limit_hit;
  assign end_evt   = accept && (done_i || abort_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b1;
      stat_o     <= '0;
      stat_vld_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      stat_vld_o <= end_evt;
      abort_o    <= abort_evt;
      if (end_evt)
        stat_o <= txs_pack(exc_coll_nxt, CCNT_FLD_W'(ccnt_nxt), exc_def_nxt, deferred_nxt);
      if (sop_i)
        open_q <= 1'b1;
      else if (end_evt)
        open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/txs_status_chk.sv
module txs_status_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         defer_chk_en_i,
  input logic [W-1:0] stat_o,
  input logic         stat_vld_o,
  input logic         abort_o,
  input logic         coll_limit_hit,
  input logic         defer_limit_hit
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_o |-> (stat_o[7] == 1'b0 && stat_o[1] == 1'b0 && stat_o[W-1:9] == '0));

  a_r3_coll_abort: assert property (@(posedge clk) disable iff (!rst_n)
    coll_limit_hit |=> (abort_o && stat_vld_o && stat_o[8]));

  a_r3_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld_o && stat_o[8]) |-> (stat_o[6:3] == 4'd0));

  a_r3_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  a_r5_defer_abort: assert property (@(posedge clk) disable iff (!rst_n)
    defer_limit_hit |=> (abort_o && stat_vld_o && stat_o[2] && stat_o[0]));

  a_r6_excdef_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    defer_limit_hit |-> defer_chk_en_i);

  a_r9_single_report: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_o |=> !stat_vld_o);

  a_r8_abort_reports: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> stat_vld_o);

endmodule

bind tx_attempt_status txs_status_chk #(.W(txs_pkg::STAT_W)) u_status_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .defer_chk_en_i  (defer_chk_en_i),
  .stat_o          (stat_o),
  .stat_vld_o      (stat_vld_o),
  .abort_o         (abort_o),
  .coll_limit_hit  (coll_limit_hit),
  .defer_limit_hit (defer_limit_hit)
);

// File: tb/test_tx_attempt_status.sv
`timescale 1ns/1ps
module test_tx_attempt_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0, coll = 1'b0, defer = 1'b0, tick = 1'b0, en = 1'b0, done = 1'b0;
  logic [15:0] stat;
  logic        vld, abort;

  int checks = 0;
  int errors = 0;
  int vld_n = 0;
  int ab_n = 0;
  logic [15:0] last_stat = '0;

  always #2.5 clk = ~clk;

  tx_attempt_status i_tx_attempt_status (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .coll_i(coll), .defer_i(defer),
    .bit_tick_i(tick), .defer_chk_en_i(en), .done_i(done),
    .stat_o(stat), .stat_vld_o(vld), .abort_o(abort)
  );

  // Status word as required by R1: b8 excess coll, b6:3 count (zero if b8), b2 excess defer, b0 deferred
  function automatic logic [15:0] exp_word(input bit ec, input int cnt, input bit ed, input bit d);
    logic [15:0] w;
    w = 16'h0;
    w[8] = ec;
    if (!ec) w[6:3] = cnt[3:0];
    w[2] = ed;
    w[0] = d;
    return w;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin vld_n++; last_stat = stat; end
      if (abort) ab_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic open_pkt(input bit chk);
    @(negedge clk); sop = 1'b1; en = chk; vld_n = 0; ab_n = 0;
    @(negedge clk); sop = 1'b0;
  endtask

  task automatic run_pkt(input int ncoll, input int ndef, input bit chk);
    open_pkt(chk);
    for (int i = 0; i < ncoll; i++) begin coll = 1'b1; @(negedge clk); end
    coll = 1'b0;
    for (int i = 0; i < ndef; i++) begin defer = 1'b1; tick = 1'b1; @(negedge clk); end
    defer = 1'b0; tick = 1'b0;
    done = 1'b1; @(negedge clk); done = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // {ncoll[5], ndef[8], chk_en[1], expected status[16], expected aborts[1]}
  localparam int NV = 7;
  localparam logic [30:0] VEC [NV] = '{
    {5'd0,  8'd0, 1'b1, 16'h0000, 1'b0},
    {5'd3,  8'd0, 1'b1, 16'h0018, 1'b0},
    {5'd0,  8'd5, 1'b1, 16'h0001, 1'b0},
    {5'd15, 8'd2, 1'b0, 16'h0079, 1'b0},
    {5'd16, 8'd0, 1'b1, 16'h0100, 1'b1},
    {5'd20, 8'd3, 1'b1, 16'h0100, 1'b1},
    {5'd1,  8'd1, 1'b0, 16'h0009, 1'b0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 stat", stat, 16'h0);
    check("R11 vld/abort", {vld, abort}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R7 R8 R9 R3: vector table
    for (int v = 0; v < NV; v++) begin
      run_pkt(int'(VEC[v][30:26]), int'(VEC[v][25:18]), VEC[v][17]);
      check($sformatf("R2/R8 vec%0d status", v), last_stat, VEC[v][16:1]);
      check($sformatf("R9 vec%0d single vld", v), vld_n, 1);
      check($sformatf("R3 vec%0d aborts", v), ab_n, VEC[v][0]);
    end

    // R3: exact timing of the sixteenth collision
    open_pkt(1'b1);
    for (int i = 0; i < 15; i++) begin coll = 1'b1; @(negedge clk); end
    check("R3 no abort at 15", ab_n, 0);
    @(negedge clk);
    check("R3 abort pulse", {abort, vld}, 2'b11);
    check("R3 status", stat, exp_word(1, 0, 0, 0));
    coll = 1'b0;
    @(negedge clk);
    check("R3 abort one cycle", {abort, vld}, 2'b00);

    // R10: SOP with same-cycle collision, then done
    @(negedge clk); sop = 1'b1; coll = 1'b1; vld_n = 0;
    @(negedge clk); sop = 1'b0; coll = 1'b0; done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R10 cleared and ignored", {vld, stat}, {1'b1, 16'h0000});

    // R8: completion in the same cycle as a collision counts it
    open_pkt(1'b1);
    coll = 1'b1; @(negedge clk);
    done = 1'b1; @(negedge clk); coll = 1'b0; done = 1'b0;
    check("R8 same-cycle count", {vld, stat}, {1'b1, exp_word(0, 2, 0, 0)});
    @(negedge clk);
    check("R8 vld one cycle", vld, 1'b0);

    // R5: excessive deferral boundary
    open_pkt(1'b1);
    defer = 1'b1; tick = 1'b1;
    for (int i = 0; i < 24288; i++) @(negedge clk);
    check("R5 no abort at limit", ab_n, 0);
    @(negedge clk);
    check("R5 abort after limit", {abort, vld}, 2'b11);
    check("R5 status", stat, exp_word(0, 0, 1, 1));
    defer = 1'b0; tick = 1'b0;
    @(negedge clk);

    // R6: check disabled, long deferral
    open_pkt(1'b0);
    defer = 1'b1; tick = 1'b1;
    for (int i = 0; i < 24400; i++) @(negedge clk);
    defer = 1'b0; tick = 1'b0; done = 1'b1; @(negedge clk); done = 1'b0;
    @(negedge clk);
    check("R6 no abort", ab_n, 0);
    check("R6 status", last_stat, exp_word(0, 0, 0, 1));

    // R6/R4: saturated timer, enable raised later; tick needed to abort
    open_pkt(1'b0);
    defer = 1'b1; tick = 1'b1;
    for (int i = 0; i < 24300; i++) @(negedge clk);
    tick = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no abort without tick", ab_n, 0);
    tick = 1'b1; @(negedge clk);
    check("R6 late enable abort", {abort, stat}, {1'b1, exp_word(0, 0, 1, 1)});
    defer = 1'b0; tick = 1'b0;
    @(negedge clk);

    // R4: ticks with defer low do not count; waits accumulate
    open_pkt(1'b1);
    tick = 1'b1;
    for (int i = 0; i < 30000; i++) @(negedge clk);
    defer = 1'b1;
    for (int i = 0; i < 20000; i++) @(negedge clk);
    defer = 1'b0;
    repeat (10) @(negedge clk);
    defer = 1'b1;
    for (int i = 0; i < 4288; i++) @(negedge clk);
    check("R4 no abort at accumulated limit", ab_n, 0);
    @(negedge clk);
    check("R4 accumulated abort", {abort, stat}, {1'b1, exp_word(0, 0, 1, 1)});
    defer = 1'b0; tick = 1'b0;

    // R9: events after report change nothing
    repeat (2) @(negedge clk);
    vld_n = 0; ab_n = 0;
    coll = 1'b1; defer = 1'b1; tick = 1'b1; done = 1'b1;
    repeat (20) @(negedge clk);
    coll = 1'b0; defer = 1'b0; tick = 1'b0; done = 1'b0;
    @(negedge clk);
    check("R9 ignored after report", {vld_n[3:0], ab_n[3:0], stat}, {4'd0, 4'd0, exp_word(0, 0, 1, 1)});

    finish_up();
  end

endmodule